// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block lays a 32x32 two-colour pointer image over a raster pixel stream. A video timing source presents, one pixel per cycle, the current beam column and line together with the pixel that lies beneath. For each pixel the block decides whether the cursor square covers that point. Where it does, a mask plane decides whether the cursor is opaque there. Where the cursor is opaque, an image plane chooses one of two cursor colours. Everywhere else the incoming pixel passes through unchanged. A flag beside the output pixel marks the pixels that came from the cursor.

Software loads the cursor through plain register writes: one packed position word and one word for each row of each plane. The position is the top-left corner of the square, so software writes the pointer location minus the hotspot. The coordinates are signed. Software hides the cursor by moving it fully off screen to (-32,-32); the block has no enable bit. A new position is held in a pending register until the next frame-start pulse, so the cursor never moves partway through a frame.

Top module: `cursor_overlay`

## Requirements
- R1: Pixel results appear on the outputs exactly two clock cycles after the cycle in which `pix_valid` is sampled high. `out_valid` is high only in those cycles.
- R2: A write to address 0 loads the position word. X is taken from bits 31:16 and Y from bits 15:0, each as a signed two's complement value, so 0xFFFC is -4.
- R3: After reset the active position is (-32,-32) and every mask and image row is zero. No pixel is selected even after mask rows are later loaded, until a new position takes effect.
- R4: A pixel at beam (bx,by) is covered when 0 <= bx-X < 32 and 0 <= by-Y < 32, computed in signed arithmetic with no wrap. The beam coordinates are unsigned.
- R5: A covered pixel uses row word number by-Y. Within that word, bit 31 is the leftmost cursor column, so column bx-X reads bit 31-(bx-X).
- R6: When the selected mask bit is 1, `cur_sel` is 1 and `pix_out` equals `color1` if the image bit is 1, or `color0` if the image bit is 0.
- R7: When the pixel is not covered, or its mask bit is 0, `cur_sel` is 0 and `pix_out` equals the `pix_in` of that pixel.
- R8: A position written while `frame_start` is low is applied at the next `frame_start` pulse. Until that pulse, pixels use the previous position.
- R9: A negative position clips the cursor at the screen edge. With X=-4 and Y=-2, beam (0,3) reads row 5, bit 27.
- R10: Write addresses are 7 bits wide. Address 64+r loads mask row r and address 96+r loads image row r, for r from 0 to 31. Every other nonzero address, such as 1 or 37, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| pix_valid | input | 1 | Beam position and pixel are valid |
| beam_x | input | 16 | Current beam column (unsigned) |
| beam_y | input | 16 | Current beam line (unsigned) |
| pix_in | input | 8 | Underlying pixel |
| color0 | input | 8 | Cursor colour used where the image bit is 0 |
| color1 | input | 8 | Cursor colour used where the image bit is 1 |
| pix_out | output | 8 | Final pixel |
| cur_sel | output | 1 | High when pix_out comes from the cursor |
| out_valid | output | 1 | Output pixel is valid |

## Verification
Each pixel passes through two registers: the coverage compare and then the plane lookup with colour choice. Its results are therefore due two rising edges after the edge that samples it. The bench drives a pixel on a falling edge and drops `pix_valid` on the next falling edge. It reads the outputs on the falling edge after that, and at the middle falling edge it also checks that `out_valid` is still low. Register writes and frame-start pulses each take one edge to land. Every write and pulse is therefore complete before the next pixel is driven, and a pixel that comes after a write but before the frame pulse must still see the old position.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

   // Destination of a register write after address decode
   typedef enum logic [1:0] {
      WT_NONE  = 2'd0,
      WT_POS   = 2'd1,
      WT_MASK  = 2'd2,
      WT_IMAGE = 2'd3
   } wr_target_e;

   // Plane select bit value inside a row address
   localparam logic PLANE_SEL_MASK  = 1'b0;
   localparam logic PLANE_SEL_IMAGE = 1'b1;

endpackage

// File: rtl/cursor_ovl_regs.sv
module cursor_ovl_regs
   import cursor_ovl_pkg::*;
#(
   parameter int unsigned CUR_DIM   = 32,
   parameter int unsigned COORD_W   = 16,
   parameter int unsigned ROW_IDX_W = $clog2(CUR_DIM),
   parameter int unsigned ADDR_W    = ROW_IDX_W + 2,
   parameter int unsigned DATA_W    = 2 * COORD_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                frame_start,
   input  logic [ROW_IDX_W-1:0] rd_row,
   output logic [COORD_W-1:0]  act_x,
   output logic [COORD_W-1:0]  act_y,
   output logic [CUR_DIM-1:0]  mask_row,
   output logic [CUR_DIM-1:0]  image_row
);

   localparam logic [COORD_W-1:0] HIDE_POS = ~COORD_W'(CUR_DIM) + 1'b1;

   wr_target_e               tgt;
   logic [ROW_IDX_W-1:0]     wr_row;
   logic [COORD_W-1:0]       pend_x, pend_y;
   logic [CUR_DIM-1:0]       mask_mem  [CUR_DIM];
   logic [CUR_DIM-1:0]       image_mem [CUR_DIM];

   // Address decode: zero is the position word, top bit set selects a row
   always_comb begin
      wr_row = wr_addr[ROW_IDX_W-1:0];
      if (!wr_en)
         tgt = WT_NONE;
      else if (wr_addr == '0)
         tgt = WT_POS;
      else if (wr_addr[ADDR_W-1])
         tgt = (wr_addr[ADDR_W-2] == PLANE_SEL_IMAGE) ? WT_IMAGE : WT_MASK;
      else
         tgt = WT_NONE;
   end

   // Pending and active position (double buffered at frame start)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_x <= HIDE_POS;
         pend_y <= HIDE_POS;
         act_x  <= HIDE_POS;
         act_y  <= HIDE_POS;
      end else begin
         if (tgt == WT_POS) begin
            pend_x <= wr_data[2*COORD_W-1:COORD_W];
            pend_y <= wr_data[COORD_W-1:0];
         end
         if (frame_start) begin
            act_x <= pend_x;
            act_y <= pend_y;
         end
      end
   end

   // One storage row per cursor line in each plane
   for (genvar r = 0; r < CUR_DIM; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_mem[r]  <= '0;
            image_mem[r] <= '0;
         end else if (wr_row == ROW_IDX_W'(r)) begin
            if (tgt == WT_MASK)
               mask_mem[r] <= wr_data[CUR_DIM-1:0];
            if (tgt == WT_IMAGE)
               image_mem[r] <= wr_data[CUR_DIM-1:0];
         end
      end
   end

   assign mask_row  = mask_mem[rd_row];
   assign image_row = image_mem[rd_row];

   AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_start) |-> ($stable(act_x) && $stable(act_y))); // R8

endmodule

// File: rtl/cursor_ovl_hit.sv
module cursor_ovl_hit #(
   parameter int unsigned CUR_DIM   = 32,
   parameter int unsigned COORD_W   = 16,
   parameter int unsigned PIX_W     = 8,
   parameter bit          MSB_LEFT  = 1'b1,
   parameter int unsigned ROW_IDX_W = $clog2(CUR_DIM)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pix_valid,
   input  logic [COORD_W-1:0]   beam_x,
   input  logic [COORD_W-1:0]   beam_y,
   input  logic [PIX_W-1:0]     pix_in,
   input  logic [COORD_W-1:0]   act_x,
   input  logic [COORD_W-1:0]   act_y,
   output logic                 s1_valid,
   output logic                 s1_hit,
   output logic [ROW_IDX_W-1:0] s1_row,
   output logic [ROW_IDX_W-1:0] s1_col,
   output logic [PIX_W-1:0]     s1_pix
);

   localparam int unsigned DW = COORD_W + 2;
   localparam logic [COORD_W-1:0] HIDE_POS = ~COORD_W'(CUR_DIM) + 1'b1;

   logic signed [DW-1:0]  dx, dy;
   logic                  in_x, in_y;
   logic [ROW_IDX_W-1:0]  col_idx;

   // Unsigned beam minus signed corner, wide enough never to wrap
   assign dx = $signed({2'b00, beam_x}) - $signed({{2{act_x[COORD_W-1]}}, act_x});
   assign dy = $signed({2'b00, beam_y}) - $signed({{2{act_y[COORD_W-1]}}, act_y});

   assign in_x = !dx[DW-1] && (dx[DW-2:0] < (DW-1)'(CUR_DIM));
   assign in_y = !dy[DW-1] && (dy[DW-2:0] < (DW-1)'(CUR_DIM));

   // Column to bit mapping variant
   if (MSB_LEFT) begin : g_msb_left
      assign col_idx = ROW_IDX_W'(CUR_DIM - 1) - dx[ROW_IDX_W-1:0];
   end else begin : g_lsb_left
      assign col_idx = dx[ROW_IDX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_hit   <= 1'b0;
         s1_row   <= '0;
         s1_col   <= '0;
         s1_pix   <= '0;
      end else begin
         s1_valid <= pix_valid;
         s1_hit   <= pix_valid && in_x && in_y;
         s1_row   <= dy[ROW_IDX_W-1:0];
         s1_col   <= col_idx;
         s1_pix   <= pix_in;
      end
   end

   AST_HIDDEN_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (act_x == HIDE_POS && act_y == HIDE_POS) |=> !s1_hit); // R3

   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !s1_hit); // R1

endmodule

// File: rtl/cursor_ovl_mix.sv
module cursor_ovl_mix #(
   parameter int unsigned CUR_DIM   = 32,
   parameter int unsigned PIX_W     = 8,
   parameter int unsigned ROW_IDX_W = $clog2(CUR_DIM)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 s1_valid,
   input  logic                 s1_hit,
   input  logic [ROW_IDX_W-1:0] s1_col,
   input  logic [PIX_W-1:0]     s1_pix,
   input  logic [CUR_DIM-1:0]   mask_row,
   input  logic [CUR_DIM-1:0]   image_row,
   input  logic [PIX_W-1:0]     color0,
   input  logic [PIX_W-1:0]     color1,
   output logic [PIX_W-1:0]     pix_out,
   output logic                 cur_sel,
   output logic                 out_valid
);

   logic mask_bit, image_bit, show;

   assign mask_bit  = mask_row[s1_col];
   assign image_bit = image_row[s1_col];
   assign show      = s1_valid && s1_hit && mask_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_out   <= '0;
         cur_sel   <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         cur_sel   <= show;
         if (show)
            pix_out <= image_bit ? color1 : color0;
         else
            pix_out <= s1_pix;
      end
   end

   AST_SEL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      cur_sel |-> out_valid); // R6

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
   parameter int unsigned CUR_DIM  = 32,
   parameter int unsigned COORD_W  = 16,
   parameter int unsigned PIX_W    = 8,
   parameter bit          MSB_LEFT = 1'b1,
   parameter int unsigned ROW_IDX_W = $clog2(CUR_DIM),
   parameter int unsigned ADDR_W   = ROW_IDX_W + 2,
   parameter int unsigned DATA_W   = 2 * COORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               frame_start,
   input  logic               pix_valid,
   input  logic [COORD_W-1:0] beam_x,
   input  logic [COORD_W-1:0] beam_y,
   input  logic [PIX_W-1:0]   pix_in,
   input  logic [PIX_W-1:0]   color0,
   input  logic [PIX_W-1:0]   color1,
   output logic [PIX_W-1:0]   pix_out,
   output logic               cur_sel,
   output logic               out_valid
);

   // Elaboration-time parameter checks
   if ((1 << ROW_IDX_W) != CUR_DIM) begin : g_chk_pow2
      $error("cursor size must be a power of two");
   end
   if (CUR_DIM > DATA_W) begin : g_chk_row
      $error("a cursor row must fit in one write word");
   end
   if (COORD_W <= ROW_IDX_W) begin : g_chk_coord
      $error("coordinate width too small for cursor size");
   end

   logic [COORD_W-1:0]   act_x, act_y;
   logic [CUR_DIM-1:0]   mask_row, image_row;
   logic                 s1_valid, s1_hit;
   logic [ROW_IDX_W-1:0] s1_row, s1_col;
   logic [PIX_W-1:0]     s1_pix;

   cursor_ovl_regs #(
      .CUR_DIM(CUR_DIM), .COORD_W(COORD_W), .ROW_IDX_W(ROW_IDX_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_start(frame_start), .rd_row(s1_row),
      .act_x(act_x), .act_y(act_y), .mask_row(mask_row), .image_row(image_row)
   );

   cursor_ovl_hit #(
      .CUR_DIM(CUR_DIM), .COORD_W(COORD_W), .PIX_W(PIX_W),
      .MSB_LEFT(MSB_LEFT), .ROW_IDX_W(ROW_IDX_W)
   ) u_hit (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .beam_x(beam_x),
      .beam_y(beam_y), .pix_in(pix_in), .act_x(act_x), .act_y(act_y),
      .s1_valid(s1_valid), .s1_hit(s1_hit), .s1_row(s1_row),
      .s1_col(s1_col), .s1_pix(s1_pix)
   );

   cursor_ovl_mix #(
      .CUR_DIM(CUR_DIM), .PIX_W(PIX_W), .ROW_IDX_W(ROW_IDX_W)
   ) u_mix (
      .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_hit(s1_hit),
      .s1_col(s1_col), .s1_pix(s1_pix), .mask_row(mask_row),
      .image_row(image_row), .color0(color0), .color1(color1),
      .pix_out(pix_out), .cur_sel(cur_sel), .out_valid(out_valid)
   );

   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(pix_valid, 2)); // R1

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !cur_sel) |-> (pix_out == $past(pix_in, 2))); // R7

   AST_SEL_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
      cur_sel |-> (pix_out == $past(color0) || pix_out == $past(color1))); // R6

endmodule

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] C0 = 8'h11;
   localparam logic [7:0] C1 = 8'h22;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [6:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        frame_start = 1'b0;
   logic        pix_valid = 1'b0;
   logic [15:0] beam_x = '0, beam_y = '0;
   logic [7:0]  pix_in = '0;
   logic [7:0]  color0 = C0, color1 = C1;
   logic [7:0]  pix_out;
   logic        cur_sel, out_valid;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cursor_overlay uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_start(frame_start), .pix_valid(pix_valid),
      .beam_x(beam_x), .beam_y(beam_y), .pix_in(pix_in), .color0(color0),
      .color1(color1), .pix_out(pix_out), .cur_sel(cur_sel), .out_valid(out_valid)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic frame();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   // Drive one pixel, read its result two edges later
   task automatic probe(input string tag, input int x, input int y, input logic [7:0] pin,
                        input logic exp_sel, input logic [7:0] exp_pix);
      @(negedge clk);
      pix_valid = 1'b1; beam_x = x[15:0]; beam_y = y[15:0]; pix_in = pin;
      @(negedge clk);
      pix_valid = 1'b0;
      @(negedge clk);
      chk({tag, " sel"}, {31'd0, cur_sel}, {31'd0, exp_sel});
      chk({tag, " pix"}, {24'd0, pix_out}, {24'd0, exp_pix});
   endtask

   task automatic t_reset();
      chk("R3 reset valid", {31'd0, out_valid}, 32'd0);
      chk("R3 reset sel", {31'd0, cur_sel}, 32'd0);
      probe("R3 reset pixel", 0, 0, 8'h5A, 1'b0, 8'h5A);
      for (int r = 0; r < 32; r++) wr(7'(64 + r), 32'hFFFF_FFFF);
      probe("R3 hidden corner", 0, 0, 8'h3C, 1'b0, 8'h3C);
      probe("R3 hidden inside", 5, 5, 8'h3D, 1'b0, 8'h3D);
      for (int r = 0; r < 32; r++) wr(7'(64 + r), 32'h0);
   endtask

   task automatic t_latency();
      @(negedge clk);
      pix_valid = 1'b1; beam_x = 16'd7; beam_y = 16'd7; pix_in = 8'h44;
      @(negedge clk);
      pix_valid = 1'b0;
      chk("R1 valid not early", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      chk("R1 valid at two cycles", {31'd0, out_valid}, 32'd1);
      @(negedge clk);
      chk("R1 valid one cycle only", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic t_load_planes();
      wr(7'd64, 32'h8000_0001);       // mask row 0
      wr(7'd96, 32'h8000_0000);       // image row 0
      wr(7'd69, 32'hFFFF_FFFF);       // mask row 5
      wr(7'd101, 32'hAAAA_AAAA);      // image row 5
      wr(7'd95, 32'h0000_0004);       // mask row 31
      wr(7'd127, 32'h0000_0004);      // image row 31
   endtask

   task automatic t_double_buffer();
      wr(7'd0, {16'd100, 16'd50});
      probe("R8 before frame", 100, 50, 8'h61, 1'b0, 8'h61);
      frame();
      probe("R8 after frame", 100, 50, 8'h62, 1'b1, C1);
   endtask

   task automatic t_window();
      probe("R5 row0 bit0 colour0", 131, 50, 8'h70, 1'b1, C0);
      probe("R7 mask clear", 101, 50, 8'h71, 1'b0, 8'h71);
      probe("R4 right of window", 132, 50, 8'h72, 1'b0, 8'h72);
      probe("R4 left of window", 99, 50, 8'h73, 1'b0, 8'h73);
      probe("R6 row5 left image1", 100, 55, 8'h74, 1'b1, C1);
      probe("R6 row5 image0", 101, 55, 8'h75, 1'b1, C0);
      probe("R4 row5 last col", 131, 55, 8'h76, 1'b1, C0);
      probe("R4 row5 past end", 132, 55, 8'h77, 1'b0, 8'h77);
      probe("R5 row31 bit2", 129, 81, 8'h78, 1'b1, C1);
      probe("R4 below window", 129, 82, 8'h79, 1'b0, 8'h79);
      probe("R4 above window", 100, 49, 8'h7A, 1'b0, 8'h7A);
   endtask

   task automatic t_ignored_addr();
      wr(7'd37, 32'h0);
      wr(7'd1, {16'd0, 16'd0});
      frame();
      probe("R10 addr37 no effect", 100, 55, 8'h80, 1'b1, C1);
      probe("R10 addr1 no move", 0, 0, 8'h81, 1'b0, 8'h81);
      probe("R2 position kept", 101, 55, 8'h82, 1'b1, C0);
   endtask

   task automatic t_negative();
      wr(7'd0, 32'hFFFC_FFFE);        // X=-4, Y=-2
      frame();
      probe("R9 clipped bit27", 0, 3, 8'h90, 1'b1, C1);
      probe("R9 clipped bit26", 1, 3, 8'h91, 1'b1, C0);
      probe("R9 clipped bit0", 27, 3, 8'h92, 1'b1, C0);
      probe("R9 clipped past end", 28, 3, 8'h93, 1'b0, 8'h93);
      probe("R2 signed Y row2", 0, 0, 8'h94, 1'b0, 8'h94);
   endtask

   task automatic t_hide_again();
      wr(7'd0, {16'hFFE0, 16'hFFE0});
      frame();
      probe("R3 hidden by position", 0, 0, 8'hA0, 1'b0, 8'hA0);
      probe("R7 hidden pass", 3, 5, 8'hA1, 1'b0, 8'hA1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latency();
      t_load_planes();
      t_double_buffer();
      t_window();
      t_ignored_addr();
      t_negative();
      t_hide_again();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      end
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      end
      $finish;
   end

endmodule